// File: doc/BRIEF.md
# Differential Pin-Pair Flag Sampler

This block lets software that bit-bangs a USB receiver read both data lines of a differential pair with a single operation. Each operation gives a pin index and a 128-bit vector of input pins. The block looks at the indexed pin, called the primary pin, and at its neighbour, called the partner pin. From these two pins it updates a carry flag and a zero flag in the style of a processor. The carry flag is XORed with the primary line, so a loop can follow line transitions. The zero flag reports the single-ended-zero state, which marks end of packet.

The partner pin is the index with bit 0 inverted. Software can therefore make either wire of the pair the primary pin. This covers the swap of the J and K states between low-speed and full/high-speed links with no extra logic. The block takes no back-pressure. An operation is accepted on every clock edge where the operation strobe is high, so the strobe needs no ready signal. Synchronising the pins to the clock and all packet-level decoding are done outside the block.

Top module: `pps_pinpair_sampler`

## Requirements
- R1: On an accepted operation (`op_vld` high at a clock edge), `pin_pri` takes `pins[pin_idx]` and `pin_par` takes the pin whose index is `pin_idx` with bit 0 inverted. An even index pairs with index+1, and an odd index pairs with index-1.
- R2: When `op_vld` and `upd_c` are both high, `flag_c` becomes its previous value XOR the primary pin.
- R3: When `op_vld` and `upd_z` are both high, `flag_z` becomes 1 only if the primary pin and the partner pin are both 0. Otherwise it becomes 0.
- R4: In an accepted operation, a flag whose update enable is low keeps its value.
- R5: When `op_vld` is low, neither flag nor either sampled pin output changes, whatever the other inputs do.
- R6: A synchronous reset (`srst` high at a clock edge) clears `flag_c`, `flag_z`, `pin_pri` and `pin_par` to 0. Reset takes priority over an operation in the same cycle.
- R7: Either pin of a pair can be the primary pin. Selecting the odd pin of a pair puts the odd pin's value on `pin_pri` and makes carry follow that pin.
- R8: With both enables high, both flags update at the same clock edge, using the same sampled pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| srst | input | 1 | Synchronous reset, active high |
| pins | input | 128 | Input pin vector, already synchronised |
| pin_idx | input | 7 | Index of the primary pin |
| op_vld | input | 1 | Operation strobe; one operation per high cycle |
| upd_c | input | 1 | Update enable for the carry flag |
| upd_z | input | 1 | Update enable for the zero flag |
| flag_c | output | 1 | Registered carry flag |
| flag_z | output | 1 | Registered zero flag |
| pin_pri | output | 1 | Registered value of the primary pin |
| pin_par | output | 1 | Registered value of the partner pin |

## Verification
The bench builds the block with its default of 128 pins and a 7-bit index. This reaches both ends of the index range (pairs 0/1 and 126/127) and also even and odd selections in the middle of the vector. Directed scenarios drive all four line states through both orientations of a pair, toggle carry in long runs, and hold the strobe or either enable low while the pins move. A pseudo-random sweep then compares the flags with a reference model over many indices.

// File: rtl/pps_pkg.sv
package pps_pkg;
  typedef struct packed {
    logic c;
    logic z;
  } pps_flags_t;

  typedef struct packed {
    logic pri;
    logic par;
  } pps_pair_t;
endpackage

// File: rtl/pps_pair_select.sv
module pps_pair_select #(
  parameter int NUM_PINS = 128,
  localparam int IDX_W = $clog2(NUM_PINS)
) (
  input  logic [NUM_PINS-1:0] pins,
  input  logic [IDX_W-1:0]    idx,
  output pps_pkg::pps_pair_t  pair
);
  // Partner view: every position holds its bit-0-flipped neighbour.
  logic [NUM_PINS-1:0] swapped;

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_swap
    assign swapped[g] = pins[g ^ 1];
  end

  assign pair.pri = pins[idx];
  assign pair.par = swapped[idx];
endmodule

// File: rtl/pps_flag_unit.sv
module pps_flag_unit (
  input  logic                 clk,
  input  logic                 srst,
  input  logic                 op_vld,
  input  logic                 upd_c,
  input  logic                 upd_z,
  input  pps_pkg::pps_pair_t   pair_in,
  output pps_pkg::pps_flags_t  flags,
  output pps_pkg::pps_pair_t   pair_q
);
  pps_pkg::pps_flags_t nxt;

  always_comb begin
    nxt = flags;
    if (upd_c) nxt.c = flags.c ^ pair_in.pri;
    if (upd_z) nxt.z = ~(pair_in.pri | pair_in.par);
  end

  always_ff @(posedge clk) begin
    if (srst) begin
      flags  <= '0;
      pair_q <= '0;
    end else if (op_vld) begin
      flags  <= nxt;
      pair_q <= pair_in;
    end
  end
endmodule

// File: rtl/pps_pinpair_sampler.sv
module pps_pinpair_sampler #(
  parameter int NUM_PINS = 128,
  localparam int IDX_W = $clog2(NUM_PINS)
) (
  input  logic                clk,
  input  logic                srst,
  input  logic [NUM_PINS-1:0] pins,
  input  logic [IDX_W-1:0]    pin_idx,
  input  logic                op_vld,
  input  logic                upd_c,
  input  logic                upd_z,
  output logic                flag_c,
  output logic                flag_z,
  output logic                pin_pri,
  output logic                pin_par
);
  pps_pkg::pps_pair_t  pair_now;
  pps_pkg::pps_pair_t  pair_reg;
  pps_pkg::pps_flags_t flags_reg;

  pps_pair_select #(.NUM_PINS(NUM_PINS)) u_sel (
    .pins (pins),
    .idx  (pin_idx),
    .pair (pair_now)
  );

  pps_flag_unit u_flags (
    .clk     (clk),
    .srst    (srst),
    .op_vld  (op_vld),
    .upd_c   (upd_c),
    .upd_z   (upd_z),
    .pair_in (pair_now),
    .flags   (flags_reg),
    .pair_q  (pair_reg)
  );

  assign flag_c  = flags_reg.c;
  assign flag_z  = flags_reg.z;
  assign pin_pri = pair_reg.pri;
  assign pin_par = pair_reg.par;
endmodule

// File: rtl/pps_pinpair_sampler_chk.sv
module pps_pinpair_sampler_chk #(
  parameter int NUM_PINS = 128,
  localparam int IDX_W = $clog2(NUM_PINS)
) (
  input logic                clk,
  input logic                srst,
  input logic [NUM_PINS-1:0] pins,
  input logic [IDX_W-1:0]    pin_idx,
  input logic                op_vld,
  input logic                upd_c,
  input logic                upd_z,
  input logic                flag_c,
  input logic                flag_z,
  input logic                pin_pri,
  input logic                pin_par
);
  logic [IDX_W-1:0] mate;
  logic line_a, line_b;
  assign mate   = {pin_idx[IDX_W-1:1], ~pin_idx[0]};
  assign line_a = pins[pin_idx];
  assign line_b = pins[mate];

  p_pair_r1: assert property (@(posedge clk) disable iff (srst)
    op_vld |=> (pin_pri == $past(line_a)) && (pin_par == $past(line_b)));

  p_carry_xor_r2: assert property (@(posedge clk) disable iff (srst)
    (op_vld && upd_c) |=> flag_c == ($past(flag_c) ^ $past(line_a)));

  p_zero_se0_r3: assert property (@(posedge clk) disable iff (srst)
    (op_vld && upd_z) |=> flag_z == !($past(line_a) || $past(line_b)));

  p_hold_c_r4: assert property (@(posedge clk) disable iff (srst)
    (op_vld && !upd_c) |=> $stable(flag_c));

  p_hold_z_r4: assert property (@(posedge clk) disable iff (srst)
    (op_vld && !upd_z) |=> $stable(flag_z));

  p_idle_r5: assert property (@(posedge clk) disable iff (srst)
    !op_vld |=> $stable({flag_c, flag_z, pin_pri, pin_par}));

  p_reset_r6: assert property (@(posedge clk)
    srst |=> !flag_c && !flag_z && !pin_pri && !pin_par);
endmodule

bind pps_pinpair_sampler pps_pinpair_sampler_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk(clk), .srst(srst), .pins(pins), .pin_idx(pin_idx), .op_vld(op_vld),
  .upd_c(upd_c), .upd_z(upd_z), .flag_c(flag_c), .flag_z(flag_z),
  .pin_pri(pin_pri), .pin_par(pin_par)
);

// File: tb/pps_pinpair_sampler_tb.sv
`timescale 1ns/1ps
module pps_pinpair_sampler_tb;
  logic clk = 1'b0;
  logic srst = 1'b1;
  logic [127:0] pins = '0;
  logic [6:0] pin_idx = '0;
  logic op_vld = 1'b0, upd_c = 1'b0, upd_z = 1'b0;
  logic flag_c, flag_z, pin_pri, pin_par;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic mc = 0, mz = 0, mp = 0, mq = 0;

  always #2.5 clk = ~clk;

  pps_pinpair_sampler u_dut (
    .clk(clk), .srst(srst), .pins(pins), .pin_idx(pin_idx), .op_vld(op_vld),
    .upd_c(upd_c), .upd_z(upd_z), .flag_c(flag_c), .flag_z(flag_z),
    .pin_pri(pin_pri), .pin_par(pin_par)
  );

  task automatic chk(string req);
    n_chk++;
    if ({flag_c, flag_z, pin_pri, pin_par} !== {mc, mz, mp, mq}) begin
      n_bad++;
      $display("FAIL %s: c/z/pri/par actual %b%b%b%b expected %b%b%b%b", req,
               flag_c, flag_z, pin_pri, pin_par, mc, mz, mp, mq);
    end
  endtask

  // One accepted operation, reference model updated from the requirements.
  task automatic op(input logic [6:0] idx, input logic [127:0] pv,
                    input logic wc, input logic wz, input string req);
    logic a, b;
    @(negedge clk);
    pins = pv; pin_idx = idx; upd_c = wc; upd_z = wz; op_vld = 1'b1;
    a = pv[idx]; b = pv[{idx[6:1], ~idx[0]}];
    if (wc) mc = mc ^ a;
    if (wz) mz = ~(a | b);
    mp = a; mq = b;
    @(posedge clk); #1;
    op_vld = 1'b0;
    chk(req);
  endtask

  task automatic do_reset(string req);
    @(negedge clk); srst = 1'b1;
    @(posedge clk); #1; srst = 1'b0;
    mc = 0; mz = 0; mp = 0; mq = 0;
    chk(req);
  endtask

  task automatic t_pairs;  // R1, R7
    op(7'd0, 128'h1, 1'b0, 1'b0, "R1 idx0");
    op(7'd1, 128'h1, 1'b0, 1'b0, "R7 idx1 odd primary");
    op(7'd126, {2'b01, 126'h0}, 1'b0, 1'b0, "R1 idx126");
    op(7'd127, {2'b01, 126'h0}, 1'b0, 1'b0, "R7 idx127");
    op(7'd43, 128'h1 << 42, 1'b0, 1'b0, "R1 idx43 partner 42");
  endtask

  task automatic t_carry;  // R2, R7
    for (int i = 0; i < 6; i++)
      op(7'd9, (i % 2) ? (128'h1 << 9) : (128'h1 << 8), 1'b1, 1'b0, "R2 carry xor");
    op(7'd8, 128'h1 << 9, 1'b1, 1'b0, "R7 swapped orientation carry");
  endtask

  task automatic t_se0;  // R3, R8
    for (int s = 0; s < 4; s++) begin
      op(7'd20, 128'(s) << 20, 1'b1, 1'b1, "R8 both flags");
      op(7'd21, 128'(s) << 20, 1'b0, 1'b1, "R3 se0 state");
    end
  endtask

  task automatic t_enables;  // R4
    op(7'd4, 128'h0, 1'b0, 1'b1, "R3 se0 set");
    op(7'd4, 128'h10, 1'b1, 1'b0, "R4 zero held");
    op(7'd4, 128'h10, 1'b0, 1'b1, "R4 carry held");
    op(7'd4, 128'h10, 1'b0, 1'b0, "R4 both held");
  endtask

  task automatic t_idle;  // R5
    @(negedge clk);
    pins = ~pins; pin_idx = pin_idx + 7'd3; upd_c = 1'b1; upd_z = 1'b1; op_vld = 1'b0;
    repeat (3) @(posedge clk);
    #1; chk("R5 no strobe");
    pins = '0; @(posedge clk); #1; chk("R5 no strobe lines low");
  endtask

  task automatic t_reset;  // R6
    op(7'd2, 128'h4, 1'b1, 1'b0, "R2 prep");
    @(negedge clk);
    srst = 1'b1; op_vld = 1'b1; upd_c = 1'b1; upd_z = 1'b1; pins = '0; pin_idx = 7'd5;
    @(posedge clk); #1; srst = 1'b0; op_vld = 1'b0;
    mc = 0; mz = 0; mp = 0; mq = 0;
    chk("R6 reset beats op");
  endtask

  task automatic t_sweep;  // R1, R2, R3
    logic [31:0] lf = 32'hACE1_1234;
    for (int k = 0; k < 200; k++) begin
      logic [127:0] pv;
      for (int w = 0; w < 4; w++) begin
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        pv[w*32 +: 32] = lf ^ {lf[15:0], lf[31:16]};
      end
      op(lf[6:0], pv, lf[9], lf[10] | lf[11], "R2 R3 sweep");
    end
  endtask

  initial begin
    repeat (2) @(posedge clk);
    #1; srst = 1'b0;
    chk("R6 reset state");
    t_pairs();
    t_carry();
    t_se0();
    t_enables();
    t_idle();
    t_reset();
    t_sweep();
    do_reset("R6 final reset");
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule